// File: doc/BRIEF.md
# Variable-Width SPI Frame Shifter

This block is the serial engine of a synchronous serial port. It moves one frame of 4 to 16 bits, most significant bit first, in the four clock modes of the common SPI format. A 4-bit size code picks the frame length at run time. Transmit words arrive right-justified from the read port of a first-word-fall-through transmit FIFO. Received words leave right-justified through the write port of a receive FIFO.

As a master, the block makes the serial clock from an external bit-rate strobe. Every strobe during a frame is one clock edge. It holds chip select low for the whole frame. As a slave, it brings the external serial clock, chip select and data into the system clock domain through a synchroniser chain, then detects edges there. A loopback control feeds the transmit shifter straight into the receive shifter. A slave output-disable lets several slaves share one return line.

Top module: `spi_frame_shifter`

## Requirements
- R1: A size code N from 3 to 15 gives a frame of N+1 bits, sent most significant bit first. Transmit word bits at position N+1 and above are ignored. A master frame makes exactly 2(N+1) serial clock edges.
- R2: The received word is right-justified with all upper bits zero. It is presented with a single-cycle rx_push one cycle after its last bit is sampled.
- R3: Size codes 0, 1 and 2 are reserved. With one of them selected, no frame starts and no word is popped.
- R4: While no master frame is running, sclk_out sits at the cpol level and cs_out_n is high. cs_out_n stays low for the whole frame, and sclk_out is back at cpol when the frame ends.
- R5: With cpha=0, data is sampled on the leading clock edge and changed on the trailing edge. With cpha=1, data changes on every leading edge after the first and is sampled on the trailing edge.
- R6: A master frame starts only on a bit_tick while the block is enabled, in master mode and with a non-empty transmit FIFO. Exactly one word is popped per frame.
- R7: With loopback set, the receive shifter takes the transmit shifter output and the sdi pin has no effect.
- R8: The master/slave select is captured only while enable is low. Changes made while enabled do not take effect.
- R9: In slave mode with slave_out_dis set, sdo_oe stays low and sdo stays 0.
- R10: busy is high while a frame is running or while the transmit FIFO is not empty.
- R11: In slave mode, a frame begins when the synchronised chip select falls. At that point a word is loaded, or zero if the FIFO is empty. The frame follows the external clock and pushes the word it received.
- R12: Dropping enable during a frame ends it at once: cs_out_n goes high and no word is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable |
| slave_sel | input | 1 | 1 selects slave mode (captured while disabled) |
| size_code | input | SIZE_W | Frame length code, length = code + 1 |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Serial clock phase |
| loopback | input | 1 | Internal transmit-to-receive path |
| slave_out_dis | input | 1 | Keep sdo undriven in slave mode |
| bit_tick | input | 1 | Half-bit rate strobe for master mode |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 2**SIZE_W | Transmit FIFO head word, right-justified |
| tx_pop | output | 1 | Transmit FIFO read strobe |
| rx_data | output | 2**SIZE_W | Received word, right-justified |
| rx_push | output | 1 | Receive FIFO write strobe |
| sclk_out | output | 1 | Serial clock out (master) |
| cs_out_n | output | 1 | Chip select out, active low (master) |
| sclk_in | input | 1 | Serial clock in (slave) |
| cs_in_n | input | 1 | Chip select in, active low (slave) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |
| sdi | input | 1 | Serial data in |
| busy | output | 1 | Frame running or transmit FIFO not empty |

## Verification
Some faults leave the port activity looking normal. A frame-length counter that stops one bit off, or a shifter that starts on the wrong edge, shows up first in the received word within one frame. Such a fault moves every bit by one place, and it also shows in the count of sclk_out edges before cs_out_n rises. A wrong sample phase in slave mode corrupts both the word shifted out on sdo and the pushed word within the same frame. A mode select that leaks through while enabled shows at the very next transmit word: the block then leaves cs_out_n high instead of starting a frame.

// File: rtl/spf_pkg.sv
package spf_pkg;

   // One serial clock edge as seen by the shift datapath
   typedef struct packed {
      logic evt;    // an edge occurs this cycle
      logic lead;   // edge leaves the idle level
   } spf_edge_t;

   // A leading edge samples when phase is 0, a trailing edge when phase is 1
   function automatic logic spf_is_sample(input logic lead, input logic phase);
      return lead ^ phase;
   endfunction

endpackage

// File: rtl/spf_sync.sv
module spf_sync #(
   parameter int          WIDTH   = 3,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spf_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spf_master_seq.sv
module spf_master_seq
   import spf_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             bit_tick,
   input  logic             cpol,
   input  logic [CNT_W-1:0] last_idx,
   output logic             run,
   output logic             sclk,
   output logic             cs_n,
   output spf_edge_t        edge_o
);

   logic [CNT_W-1:0] k_q;
   logic [CNT_W-1:0] last_q;
   logic             sclk_q;
   logic             pol_q;
   logic             cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         k_q    <= '0;
         last_q <= '0;
         sclk_q <= 1'b0;
         pol_q  <= 1'b0;
         cs_q   <= 1'b1;
      end else if (abort) begin
         run  <= 1'b0;
         cs_q <= 1'b1;
      end else if (start) begin
         run    <= 1'b1;
         k_q    <= '0;
         last_q <= last_idx;
         sclk_q <= cpol;
         pol_q  <= cpol;
         cs_q   <= 1'b0;
      end else if (run && bit_tick) begin
         sclk_q <= ~sclk_q;
         if (k_q == last_q) begin
            run  <= 1'b0;
            cs_q <= 1'b1;
         end else begin
            k_q <= k_q + CNT_W'(1);
         end
      end
   end

   assign sclk        = run ? sclk_q : cpol;
   assign cs_n        = cs_q;
   assign edge_o.evt  = run && bit_tick && !abort;
   assign edge_o.lead = ~k_q[0];

   // R4: chip select low for the whole frame
   p_cs_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !cs_q);

   // R4: a completed frame leaves the clock at its idle level
   p_idle_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run) && !$past(abort)) |-> (sclk_q == pol_q));

endmodule

// File: rtl/spf_slave_front.sv
module spf_slave_front
   import spf_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sclk_in,
   input  logic      cs_in_n,
   input  logic      sdi_in,
   input  logic      cpol,
   output spf_edge_t edge_o,
   output logic      cs_fall,
   output logic      cs_low,
   output logic      sdi_s
);

   logic [2:0] raw;
   logic [2:0] synced;
   logic       sclk_d;
   logic       csn_d;

   assign raw = {cs_in_n, sclk_in, sdi_in};

   spf_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (synced)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         csn_d  <= 1'b1;
      end else begin
         sclk_d <= synced[1];
         csn_d  <= synced[2];
      end
   end

   assign cs_low      = ~synced[2];
   assign cs_fall     = csn_d & ~synced[2];
   assign sdi_s       = synced[0];
   assign edge_o.evt  = cs_low && (synced[1] != sclk_d);
   assign edge_o.lead = (synced[1] != cpol);

   // R11: a chip select fall is a single-cycle event
   p_cs_fall_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> !cs_fall);

endmodule

// File: rtl/spf_shift_dp.sv
module spf_shift_dp
   import spf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BIT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic [BIT_W-1:0]  nbits,
   input  logic              cpha,
   input  logic              abort,
   input  spf_edge_t         edge_i,
   input  logic              sdi,
   output logic              sdo_bit,
   output logic [DATA_W-1:0] rx_word,
   output logic              rx_push
);

   localparam logic [BIT_W-1:0] FULL = BIT_W'(DATA_W);

   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_sh;
   logic [BIT_W-1:0]  cnt_q;
   logic [BIT_W-1:0]  nb_q;
   logic              armed;
   logic              fresh;
   logic              cpha_q;
   logic              push_q;
   logic              smp;

   assign smp = spf_is_sample(edge_i.lead, cpha_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh  <= '0;
         rx_sh  <= '0;
         cnt_q  <= '0;
         nb_q   <= FULL;
         armed  <= 1'b0;
         fresh  <= 1'b0;
         cpha_q <= 1'b0;
         push_q <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (load) begin
            tx_sh  <= load_word << (FULL - nbits);
            rx_sh  <= '0;
            cnt_q  <= '0;
            nb_q   <= nbits;
            armed  <= 1'b1;
            fresh  <= 1'b1;
            cpha_q <= cpha;
         end else if (abort) begin
            armed <= 1'b0;
         end else if (edge_i.evt && armed) begin
            fresh <= 1'b0;
            if (smp) begin
               rx_sh <= {rx_sh[DATA_W-2:0], sdi};
               cnt_q <= cnt_q + BIT_W'(1);
               if (cnt_q == nb_q - BIT_W'(1)) begin
                  armed  <= 1'b0;
                  push_q <= 1'b1;
               end
            end else if (!fresh) begin
               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign sdo_bit = tx_sh[DATA_W-1];
   assign rx_word = rx_sh;
   assign rx_push = push_q;

   // R2: the pushed word has nothing above the frame length
   p_rx_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> ((rx_word >> nb_q) == '0));

   // R2: one push per frame
   p_push_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |=> !rx_push);

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
   import spf_pkg::*;
#(
   parameter int SIZE_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int MIN_CODE    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  slave_sel,
   input  logic [SIZE_W-1:0]     size_code,
   input  logic                  cpol,
   input  logic                  cpha,
   input  logic                  loopback,
   input  logic                  slave_out_dis,
   input  logic                  bit_tick,
   input  logic                  tx_empty,
   input  logic [(1<<SIZE_W)-1:0] tx_data,
   output logic                  tx_pop,
   output logic [(1<<SIZE_W)-1:0] rx_data,
   output logic                  rx_push,
   output logic                  sclk_out,
   output logic                  cs_out_n,
   input  logic                  sclk_in,
   input  logic                  cs_in_n,
   output logic                  sdo,
   output logic                  sdo_oe,
   input  logic                  sdi,
   output logic                  busy
);

   localparam int DATA_W = 1 << SIZE_W;
   localparam int BIT_W  = SIZE_W + 1;
   localparam int CNT_W  = SIZE_W + 2;

   if (SIZE_W < 2 || SIZE_W > 6) begin : g_bad_size
      $error("SIZE_W out of supported range");
   end
   if (MIN_CODE < 1 || MIN_CODE >= DATA_W) begin : g_bad_min
      $error("MIN_CODE out of range");
   end

   logic             slave_q;
   logic             code_ok;
   logic [BIT_W-1:0] nbits;
   logic [CNT_W-1:0] last_idx;
   logic             m_start;
   logic             m_run;
   logic             m_sclk;
   logic             m_csn;
   spf_edge_t        m_edge;
   spf_edge_t        s_edge;
   spf_edge_t        dp_edge;
   logic             s_cs_fall;
   logic             s_cs_low;
   logic             s_sdi;
   logic             s_load;
   logic             s_active;
   logic             dp_load;
   logic             dp_abort;
   logic             sdo_bit;
   logic             sdi_eff;

   // mode select only follows its input while disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slave_q <= 1'b0;
      else if (!enable) slave_q <= slave_sel;
   end

   assign code_ok  = (size_code >= SIZE_W'(MIN_CODE));
   assign nbits    = {1'b0, size_code} + BIT_W'(1);
   assign last_idx = {1'b0, nbits, 1'b0} - CNT_W'(1);

   assign m_start = enable && !slave_q && code_ok && !tx_empty && bit_tick && !m_run;

   spf_master_seq #(.CNT_W(CNT_W)) u_mseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (m_start),
      .abort   (!enable),
      .bit_tick(bit_tick),
      .cpol    (cpol),
      .last_idx(last_idx),
      .run     (m_run),
      .sclk    (m_sclk),
      .cs_n    (m_csn),
      .edge_o  (m_edge)
   );

   spf_slave_front #(.STAGES(SYNC_STAGES)) u_sfront (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_in(sclk_in),
      .cs_in_n(cs_in_n),
      .sdi_in (sdi),
      .cpol   (cpol),
      .edge_o (s_edge),
      .cs_fall(s_cs_fall),
      .cs_low (s_cs_low),
      .sdi_s  (s_sdi)
   );

   assign s_load = enable && slave_q && code_ok && s_cs_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 s_active <= 1'b0;
      else if (!enable || !slave_q || !s_cs_low)  s_active <= 1'b0;
      else if (s_load)                            s_active <= 1'b1;
   end

   assign dp_load  = m_start || s_load;
   assign dp_abort = !enable || (slave_q && !s_cs_low);
   assign dp_edge  = slave_q ? s_edge : m_edge;
   assign sdi_eff  = loopback ? sdo_bit : (slave_q ? s_sdi : sdi);

   spf_shift_dp #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dp_load),
      .load_word(tx_empty ? '0 : tx_data),
      .nbits    (nbits),
      .cpha     (cpha),
      .abort    (dp_abort),
      .edge_i   (dp_edge),
      .sdi      (sdi_eff),
      .sdo_bit  (sdo_bit),
      .rx_word  (rx_data),
      .rx_push  (rx_push)
   );

   assign tx_pop   = m_start || (s_load && !tx_empty);
   assign sclk_out = slave_q ? cpol : m_sclk;
   assign cs_out_n = slave_q ? 1'b1 : m_csn;
   assign sdo_oe   = enable && (!slave_q || (s_cs_low && !slave_out_dis));
   assign sdo      = sdo_oe & sdo_bit;
   assign busy     = m_run || s_active || !tx_empty;

   // R8: mode register frozen while enabled
   p_mode_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(enable) |-> $stable(slave_q));

   // R6: one pop per frame start
   p_one_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pop |=> !tx_pop);

   // R3: reserved length codes never consume a word
   p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !code_ok |-> !tx_pop);

   // R12: a disabled block releases chip select
   p_abort_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!enable) |-> cs_out_n);

endmodule

// File: tb/spi_frame_shifter_bench.sv
`timescale 1ns/1ps
module spi_frame_shifter_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        slave_sel = 1'b0;
   logic [3:0]  size_code = 4'd7;
   logic        cpol = 1'b0;
   logic        cpha = 1'b0;
   logic        loopback = 1'b0;
   logic        slave_out_dis = 1'b0;
   logic        bit_tick;
   logic        tx_empty = 1'b1;
   logic [15:0] tx_data = '0;
   logic        tx_pop;
   logic [15:0] rx_data;
   logic        rx_push;
   logic        sclk_out, cs_out_n;
   logic        sclk_in = 1'b0;
   logic        cs_in_n = 1'b1;
   logic        sdo, sdo_oe;
   logic        sdi;
   logic        busy;

   logic        slave_test = 1'b0;
   logic        sdi_drv = 1'b0;
   logic        sdi_mdl = 1'b0;
   logic [1:0]  div = '0;

   int          checks = 0;
   int          fails = 0;
   int          pop_cnt = 0;
   int          push_cnt = 0;
   int          tog = 0;
   logic [15:0] rx_got = '0;
   logic        sclk_prev = 1'b0;

   // bench-side slave model state
   logic [15:0] s_word = '0;
   logic [15:0] mcap = '0;
   int          n_b = 8;
   int          idx = 0;
   logic        first = 1'b0;
   logic        cs_prev = 1'b1;
   logic        sc_prev = 1'b0;

   always #5 clk = ~clk;

   assign bit_tick = &div;
   assign sdi = slave_test ? sdi_drv : sdi_mdl;

   spi_frame_shifter u_spi_frame_shifter (
      .clk(clk), .rst_n(rst_n), .enable(enable), .slave_sel(slave_sel),
      .size_code(size_code), .cpol(cpol), .cpha(cpha), .loopback(loopback),
      .slave_out_dis(slave_out_dis), .bit_tick(bit_tick), .tx_empty(tx_empty),
      .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data), .rx_push(rx_push),
      .sclk_out(sclk_out), .cs_out_n(cs_out_n), .sclk_in(sclk_in),
      .cs_in_n(cs_in_n), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi), .busy(busy)
   );

   always @(posedge clk) begin
      div <= div + 2'd1;
      sclk_prev <= sclk_out;
      if (sclk_out != sclk_prev) tog <= tog + 1;
      if (tx_pop) begin
         tx_empty <= 1'b1;
         pop_cnt  <= pop_cnt + 1;
      end
      if (rx_push) begin
         rx_got   <= rx_data;
         push_cnt <= push_cnt + 1;
      end
   end

   // slave-side model for master frames: captures sdo, supplies sdi
   always @(negedge clk) begin
      if (cs_prev && !cs_out_n) begin
         idx = n_b - 1;
         sdi_mdl = s_word[idx];
         first = 1'b1;
         mcap = '0;
      end else if ((!cs_out_n || !cs_prev) && sclk_out != sc_prev) begin
         if (sclk_out != cpol) begin
            if (!cpha) mcap = {mcap[14:0], sdo};
            else begin
               if (!first && idx > 0) idx = idx - 1;
               first = 1'b0;
               sdi_mdl = s_word[idx];
            end
         end else begin
            if (!cpha) begin
               if (idx > 0) idx = idx - 1;
               sdi_mdl = s_word[idx];
            end else mcap = {mcap[14:0], sdo};
         end
      end
      cs_prev = cs_out_n;
      sc_prev = sclk_out;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic int mask_of(input int n);
      return (32'h1 << n) - 1;
   endfunction

   task automatic master_frame(input int code, input int mode, input bit lb,
                               input logic [15:0] word, input logic [15:0] sword);
      int t0, p0, q0, m;
      @(negedge clk);
      size_code = 4'(code); cpol = mode[1]; cpha = mode[0]; loopback = lb;
      s_word = sword; n_b = code + 1;
      repeat (3) @(negedge clk);
      t0 = tog; p0 = push_cnt; q0 = pop_cnt; m = mask_of(code + 1);
      tx_data = word; tx_empty = 1'b0;
      for (int i = 0; i < 400 && push_cnt == p0; i++) @(negedge clk);
      for (int i = 0; i < 20 && !cs_out_n; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      if (lb) check(rx_got == (word & m), "R7 loopback word", rx_got, word & m);
      else begin
         check(rx_got == (sword & m), "R5 master rx word", rx_got, sword & m);
         check(mcap == (word & m), "R1 master sdo bits", mcap, word & m);
      end
      check(tog - t0 == 2 * (code + 1), "R1 clock edge count", tog - t0, 2 * (code + 1));
      check(sclk_out == cpol && cs_out_n, "R4 idle levels", {sclk_out, cs_out_n}, {cpol, 1'b1});
      check(pop_cnt - q0 == 1, "R6 one pop", pop_cnt - q0, 1);
   endtask

   task automatic slave_frame(input int code, input int mode, input bit odis,
                              input logic [15:0] sword, input logic [15:0] mword);
      int p0, m;
      logic [15:0] cap;
      logic oe_seen;
      @(negedge clk);
      enable = 1'b0; slave_sel = 1'b1; slave_test = 1'b1;
      size_code = 4'(code); cpol = mode[1]; cpha = mode[0];
      loopback = 1'b0; slave_out_dis = odis;
      sclk_in = mode[1]; cs_in_n = 1'b1;
      @(negedge clk); enable = 1'b1;
      tx_data = sword; tx_empty = 1'b0;
      repeat (10) @(negedge clk);
      p0 = push_cnt; m = mask_of(code + 1); cap = '0; oe_seen = 1'b0;
      cs_in_n = 1'b0;
      repeat (10) @(negedge clk);
      for (int i = code; i >= 0; i--) begin
         if (!mode[0]) begin
            sdi_drv = mword[i];
            repeat (10) @(negedge clk);
            cap = {cap[14:0], sdo}; oe_seen |= sdo_oe;
            sclk_in = ~mode[1];
            repeat (10) @(negedge clk);
            sclk_in = mode[1];
         end else begin
            sclk_in = ~mode[1];
            sdi_drv = mword[i];
            repeat (10) @(negedge clk);
            cap = {cap[14:0], sdo}; oe_seen |= sdo_oe;
            sclk_in = mode[1];
            repeat (10) @(negedge clk);
         end
      end
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R10 busy in slave frame", busy, 1);
      cs_in_n = 1'b1;
      repeat (10) @(negedge clk);
      check(push_cnt - p0 == 1, "R11 slave push", push_cnt - p0, 1);
      check(rx_got == (mword & m), "R11 slave rx word", rx_got, mword & m);
      if (odis) begin
         check(!oe_seen && cap == 0, "R9 slave output disabled", {oe_seen, cap}, 0);
      end else begin
         check(cap == (sword & m), "R11 slave sdo bits", cap, sword & m);
      end
      @(negedge clk);
      enable = 1'b0; slave_sel = 1'b0; slave_test = 1'b0;
      @(negedge clk); enable = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int p0, q0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 / R10 reset state
      check(cs_out_n && sclk_out == 1'b0, "R4 reset levels", {cs_out_n, sclk_out}, 2'b10);
      check(!rx_push && !tx_pop, "R2 reset strobes", {rx_push, tx_pop}, 0);
      check(!busy, "R10 reset busy", busy, 0);
      // R10 busy follows a waiting word while disabled
      tx_data = 16'h1234; tx_empty = 1'b0;
      @(negedge clk);
      check(busy, "R10 busy with pending word", busy, 1);
      check(pop_cnt == 0, "R6 no start while disabled", pop_cnt, 0);
      tx_empty = 1'b1;
      @(negedge clk);
      check(!busy, "R10 idle busy", busy, 0);
      enable = 1'b1; sdi_mdl = 1'b1;

      // R1/R2/R7 loopback sweep over every legal length and mode
      for (int c = 3; c < 16; c++)
         for (int md = 0; md < 4; md++)
            master_frame(c, md, 1'b1, 16'(16'hA5C3 ^ (c * 16'h0F1D) ^ (md * 16'h3301)), 16'hFFFF);

      // R5 external sdi with a bench slave in every mode
      for (int c = 3; c < 16; c += 4)
         for (int md = 0; md < 4; md++)
            master_frame(c, md, 1'b0, 16'(16'h6B2D + c * 16'h1111 + md), 16'(16'hC3A9 ^ (c << md)));

      // R3 reserved codes
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         size_code = 4'(c); q0 = pop_cnt;
         tx_data = 16'hFFFF; tx_empty = 1'b0;
         repeat (40) @(negedge clk);
         check(pop_cnt == q0 && cs_out_n, "R3 reserved code idle", pop_cnt - q0, 0);
         tx_empty = 1'b1;
      end

      // R8 slave select changed while enabled is ignored
      @(negedge clk); slave_sel = 1'b1;
      master_frame(7, 0, 1'b1, 16'h005A, 16'h0000);
      check(cs_out_n, "R8 master mode kept", cs_out_n, 1);
      @(negedge clk); slave_sel = 1'b0;

      // R12 abort mid-frame, R10 busy during frame
      @(negedge clk);
      size_code = 4'd15; cpol = 1'b0; cpha = 1'b0; loopback = 1'b1;
      p0 = push_cnt; q0 = pop_cnt;
      tx_data = 16'hBEEF; tx_empty = 1'b0;
      for (int i = 0; i < 20 && pop_cnt == q0; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      check(busy && !cs_out_n, "R10 busy mid-frame", {busy, cs_out_n}, 2'b10);
      enable = 1'b0;
      @(negedge clk);
      check(cs_out_n, "R12 cs released on disable", cs_out_n, 1);
      repeat (200) @(negedge clk);
      check(push_cnt == p0, "R12 no push after abort", push_cnt - p0, 0);
      check(sclk_out == cpol, "R12 clock idle after abort", sclk_out, cpol);
      enable = 1'b1;

      // R11 / R9 slave frames
      slave_frame(7, 0, 1'b0, 16'h00C5, 16'h003A);
      slave_frame(15, 3, 1'b0, 16'h9E37, 16'h4C1B);
      slave_frame(4, 1, 1'b0, 16'hFF15, 16'h000A);
      slave_frame(11, 2, 1'b0, 16'h0A5C, 16'h0FC3);
      slave_frame(11, 2, 1'b1, 16'h0A5C, 16'h0123);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule